// File: doc/BRIEF.md
# Ripple-Carry Integer ALU

This block is a purely combinational integer arithmetic logic unit for a datapath. Two operands and a three-bit operation code go in; a result word, a zero flag and a signed overflow flag come out in the same cycle. The datapath is a chain of identical one-bit slices. Each slice holds a full adder, an optional inverter on its second operand and a four-way selector that picks the AND, OR or sum bit, or a "less" input.

Subtraction does not need a separate subtractor. The second operand is inverted and the chain's carry-in is forced to one, which adds the two's-complement negative of that operand. The signed comparison runs the same subtraction. It takes the sign of the exact difference, which is the adder's top bit corrected by the overflow, and routes it into the lowest slice through that slice's "less" input.

A control path uses the zero flag after a subtraction to test two operands for equality. It uses the overflow flag as a status bit and takes no other action on it.

Top module: `alu_ripple`

## Requirements
- R1: Operation code 3'b000 returns the bitwise AND of the two operands.
- R2: Operation code 3'b001 returns the bitwise OR of the two operands.
- R3: Operation code 3'b010 returns the sum of the operands modulo 2^WIDTH.
- R4: Operation code 3'b110 returns the first operand minus the second, modulo 2^WIDTH, computed as first + ~second + 1.
- R5: Operation code 3'b111 returns 1 in bit 0 when the first operand is less than the second as signed numbers, 0 otherwise, with all other result bits 0; this stays correct when the internal difference overflows.
- R6: The zero flag is 1 exactly when every result bit is 0 (so after 3'b110 it signals equal operands).
- R7: For 3'b010 the overflow flag is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it; operands of opposite sign never overflow.
- R8: For 3'b110 the overflow flag is 1 exactly when the operands have different sign bits and the result's sign bit differs from the first operand's.
- R9: For 3'b000, 3'b001 and 3'b111 the overflow flag is 0.
- R10: The unused codes 3'b011, 3'b100 and 3'b101 give a result of all zeros, a zero flag of 1 and an overflow flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The embedded checks are immediate and evaluated whenever the combinational logic settles. They assume that operands and operation code are fully known values and that they hold still while the outputs are read, and they skip evaluation while any input is unknown. The stimulus changes all inputs together just after one clock edge and reads the outputs at the opposite edge, so a check never sees an operand half-way through an update. Every one of the eight operation codes is driven, including the three unused ones, so the checks on the unused codes are reached.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } slice_pick_e;

  typedef struct packed {
    logic        b_invert;
    logic        carry_in;
    slice_pick_e pick;
    logic        result_en;
    logic        ovf_en;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
`timescale 1ns/1ps
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{b_invert: 1'b0, carry_in: 1'b0, pick: PICK_AND,
               result_en: 1'b0, ovf_en: 1'b0};
    case (op_i)
      ALU_AND: begin
        ctrl_o.pick      = PICK_AND;
        ctrl_o.result_en = 1'b1;
      end
      ALU_OR: begin
        ctrl_o.pick      = PICK_OR;
        ctrl_o.result_en = 1'b1;
      end
      ALU_ADD: begin
        ctrl_o.pick      = PICK_SUM;
        ctrl_o.result_en = 1'b1;
        ctrl_o.ovf_en    = 1'b1;
      end
      ALU_SUB: begin
        ctrl_o.b_invert  = 1'b1;
        ctrl_o.carry_in  = 1'b1;
        ctrl_o.pick      = PICK_SUM;
        ctrl_o.result_en = 1'b1;
        ctrl_o.ovf_en    = 1'b1;
      end
      ALU_SLT: begin
        // same subtraction, result taken from the less path
        ctrl_o.b_invert  = 1'b1;
        ctrl_o.carry_in  = 1'b1;
        ctrl_o.pick      = PICK_LESS;
        ctrl_o.result_en = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        cin_i,
  input  logic        less_i,
  input  logic        b_invert_i,
  input  slice_pick_e pick_i,
  output logic        res_o,
  output logic        sum_o,
  output logic        cout_o
);

  logic b_eff;

  assign b_eff  = b_i ^ b_invert_i;
  assign sum_o  = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    case (pick_i)
      PICK_AND:  res_o = a_i & b_i;
      PICK_OR:   res_o = a_i | b_i;
      PICK_SUM:  res_o = sum_o;
      default:   res_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic             sum_msb_i,
  input  logic             carry_into_msb_i,
  input  logic             carry_out_msb_i,
  input  logic             ovf_en_i,
  input  logic [WIDTH-1:0] result_i,
  output logic             less_o,
  output logic             ovf_o,
  output logic             zero_o
);

  logic raw_ovf;

  // signed overflow: carry into sign bit differs from carry out of it
  assign raw_ovf = carry_into_msb_i ^ carry_out_msb_i;
  // sign of the exact difference, valid even when raw_ovf is set
  assign less_o  = sum_msb_i ^ raw_ovf;
  assign ovf_o   = ovf_en_i & raw_ovf;
  assign zero_o  = ~|result_i;

endmodule

// File: rtl/alu_ripple.sv
`timescale 1ns/1ps
module alu_ripple
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] slice_res;
  logic [WIDTH-1:0] slice_sum;
  logic             less_bit;

  alu_op_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign carry[0] = ctrl.carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less_bit;
    end else begin : g_upper
      assign less_in = 1'b0;
    end

    alu_bit_slice u_slice (
      .a_i        (a_i[i]),
      .b_i        (b_i[i]),
      .cin_i      (carry[i]),
      .less_i     (less_in),
      .b_invert_i (ctrl.b_invert),
      .pick_i     (ctrl.pick),
      .res_o      (slice_res[i]),
      .sum_o      (slice_sum[i]),
      .cout_o     (carry[i+1])
    );
  end

  assign result_o = ctrl.result_en ? slice_res : '0;

  alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .sum_msb_i        (slice_sum[MSB]),
    .carry_into_msb_i (carry[MSB]),
    .carry_out_msb_i  (carry[WIDTH]),
    .ovf_en_i         (ctrl.ovf_en),
    .result_i         (result_o),
    .less_o           (less_bit),
    .ovf_o            (overflow_o),
    .zero_o           (zero_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == ALU_SUB) begin
        // R4
        sub_inverse_chk: assert (result_o + b_i == a_i)
          else $error("sub result does not add back to a");
        // R6
        sub_equal_zero_chk: assert (zero_o == (a_i == b_i))
          else $error("zero flag disagrees with operand equality");
      end
      if (op_i == ALU_SLT) begin
        // R5
        slt_result_chk: assert (result_o ==
                                {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
          else $error("set-less-than result wrong");
      end
      if (op_i == ALU_ADD && (a_i[MSB] != b_i[MSB])) begin
        // R7
        mixed_sign_add_chk: assert (!overflow_o)
          else $error("overflow on mixed-sign add");
      end
      if (op_i == ALU_AND || op_i == ALU_OR || op_i == ALU_SLT) begin
        // R9
        no_overflow_chk: assert (!overflow_o)
          else $error("overflow raised on non-arithmetic op");
      end
      if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
        // R10
        unused_op_chk: assert (result_o == '0 && zero_o && !overflow_o)
          else $error("unused op code produced output");
      end
    end
  end

endmodule

// File: tb/alu_ripple_tb_top.sv
`timescale 1ns/1ps
module alu_ripple_tb_top;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         z;
    logic         v;
  } exp_item_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [2:0]   op;
  logic [W-1:0] result;
  logic         zero;
  logic         ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  exp_item_t exp_q[$];
  exp_item_t cur;

  alu_ripple #(.WIDTH(W)) dut_i (
    .a_i        (a),
    .b_i        (b),
    .op_i       (op),
    .result_o   (result),
    .zero_o     (zero),
    .overflow_o (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_item_t model(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] o);
    exp_item_t e;
    e.a = x; e.b = y; e.op = o; e.v = 1'b0;
    case (o)
      3'b000: e.res = x & y;
      3'b001: e.res = x | y;
      3'b010: begin
        e.res = x + y;
        e.v   = (x[W-1] == y[W-1]) && (e.res[W-1] != x[W-1]);
      end
      3'b110: begin
        e.res = x - y;
        e.v   = (x[W-1] != y[W-1]) && (e.res[W-1] != x[W-1]);
      end
      3'b111: e.res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      default: e.res = '0;
    endcase
    e.z = (e.res == '0);
    return e;
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] o);
    @(posedge clk);
    #1;
    a  = x;
    b  = y;
    op = o;
    exp_q.push_back(model(x, y, o));
  endtask

  // monitor: compare at the falling edge after each drive
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      string rtag, vtag;
      cur = exp_q.pop_front();
      case (cur.op)
        3'b000: begin rtag = "R1"; vtag = "R9"; end
        3'b001: begin rtag = "R2"; vtag = "R9"; end
        3'b010: begin rtag = "R3"; vtag = "R7"; end
        3'b110: begin rtag = "R4"; vtag = "R8"; end
        3'b111: begin rtag = "R5"; vtag = "R9"; end
        default: begin rtag = "R10"; vtag = "R10"; end
      endcase
      chk(rtag, result, cur.res);
      chk("R6", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, cur.z});
      chk(vtag, {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, cur.v});
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] corners [8];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000;
    corners[5] = 32'h5555_5555;
    corners[6] = 32'hAAAA_AAAA;
    corners[7] = 32'h8000_0001;

    rst_n = 1'b0;
    a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle inputs: AND of zeros
    chk("R1", result, '0);
    chk("R6", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
    chk("R9", {{(W-1){1'b0}}, ovf}, '0);
    rst_n = 1'b1;

    // all ops, including unused codes, over corner operand pairs
    for (int oi = 0; oi < 8; oi++)
      for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++)
          drive(corners[ai], corners[bi], 3'(oi));

    // equal operands for the zero flag after subtract
    drive(32'h1234_5678, 32'h1234_5678, 3'b110);
    drive(32'h8000_0000, 32'h8000_0000, 3'b110);

    // random operands
    for (int k = 0; k < 600; k++)
      drive($urandom, $urandom, 3'($urandom_range(0, 7)));

    // random with small magnitudes around zero
    for (int k = 0; k < 200; k++)
      drive(32'($signed($urandom_range(0, 8)) - 4),
            32'($signed($urandom_range(0, 8)) - 4),
            3'($urandom_range(0, 7)));

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end

endmodule